// File: doc/BRIEF.md
# Instruction Fetch Address Watch Unit

This block is a small debug watch unit. It observes the start address of every instruction fetch on a 24-bit address bus. It emits a one-cycle detect pulse when a condition chosen by software holds for that fetch. Software on a byte-wide register bus selects the condition and writes two 24-bit compare addresses.

Four conditions exist: the fetch equals compare address 0, it equals compare address 1, it equals either of them, or it lies outside the window that the two addresses bound. In the either-address mode a readable status bit reports which address matched. The compare registers can be reached only while an access-enable bit is set. The condition select and the enable survive a system reset and clear only at power-on.

Top module: `dbg_addr_watch`

## Requirements
- R1: Control register 0 (byte address 0x66) bits [2:0] pick the condition. 3'b001 detects fetch address == compare 0. 3'b010 detects fetch address == compare 1. 3'b011 detects a match with either one. 3'b101 detects an address below compare 0 or above compare 1. Codes 000, 100, 110 and 111 never detect.
- R2: Control register 0 bit 4 enables detection; while it is 0 no detect pulse is produced for any select code or address.
- R3: `detect_pulse` is high for exactly the one cycle after a cycle in which `fetch_strobe` was high with an address meeting the enabled condition. It is never high after a cycle without `fetch_strobe`.
- R4: Compare 0 occupies byte addresses 0x68 (bits 7:0), 0x69 (15:8) and 0x6A (23:16). Compare 1 occupies 0x6B, 0x6C and 0x6D in the same order. These bytes are written and read only while control register 1 (0x67) bit 2 is 1. Otherwise a write leaves them unchanged and a read returns 0x00.
- R5: When an either-address detect fires, control register 1 bit 5 is updated on the same edge as the pulse. It becomes 0 if compare 0 matched, including when both match, and 1 if only compare 1 matched. Other modes leave it unchanged.
- R6: `por_n` low clears everything, including the select field and the enable. `sys_rst_n` low clears the access enable, the status bit and the pulse, but keeps the select field and the enable. Register writes are ignored while either reset is low.
- R7: Control register 0 reads bit 7 as 1 and bits 3, 5 and 6 as 0, whatever was written. Control register 1 reads bit 2 as the access enable, bit 3 as `dbg_attached`, bit 5 as the status bit, and all other bits as 0.
- R8: `reg_rdata` shows the addressed register in the same cycle, with no register on the path; any address not listed above reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| sys_rst_n | input | 1 | Hardware/software reset, synchronous, active low |
| reg_addr | input | 8 | Register bus byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dbg_attached | input | 1 | High while a debugger is connected |
| fetch_strobe | input | 1 | Marks a new instruction start address |
| fetch_addr | input | 24 | Instruction start address |
| detect_pulse | output | 1 | One-cycle detect pulse |

## Verification
Each mode is tried with an exact hit, a neighbour one above the hit, and the other register's address. This separates the equality modes from each other and from off-by-one decoding. The window mode is probed just below, at, and just above each bound to fix whether the bounds are inclusive. The either-address mode runs with a hit on register 0 only, on register 1 only, and on both together, which exposes the status-bit priority. Unused codes, a cleared enable, and a held match address without a strobe each show that no pulse can leak. A locked write followed by an unlocked read-back, plus one system-reset and one power-on pulse, separate the retained bits from the cleared ones.

// File: rtl/dbg_watch_pkg.sv
// Package: shared register map and condition codes of the fetch address watch unit.
// Assumes an 8-bit register bus address and exactly two compare registers.
package dbg_watch_pkg;
    localparam int REG_AW   = 8;
    localparam int NUM_CMP  = 2;

    localparam logic [REG_AW-1:0] ADR_CTRL0    = 8'h66;
    localparam logic [REG_AW-1:0] ADR_CTRL1    = 8'h67;
    localparam logic [REG_AW-1:0] ADR_CMP_BASE = 8'h68;

    localparam logic [2:0] SEL_CMP0    = 3'b001;
    localparam logic [2:0] SEL_CMP1    = 3'b010;
    localparam logic [2:0] SEL_EITHER  = 3'b011;
    localparam logic [2:0] SEL_OUTSIDE = 3'b101;

    localparam int CTRL0_EN_BIT    = 4;
    localparam int CTRL0_ONE_BIT   = 7;
    localparam int CTRL1_ACC_BIT   = 2;
    localparam int CTRL1_DBG_BIT   = 3;
    localparam int CTRL1_WHICH_BIT = 5;
endpackage

// File: rtl/dbg_ctrl_regs.sv
// Control register storage. The select field and the enable clear only on power-on
// reset. The access enable clears on either reset. Writes are ignored during any reset.
module dbg_ctrl_regs
    import dbg_watch_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [2:0]        sel_o,
    output logic              en_o,
    output logic              acc_en_o
);
    logic [2:0] sel_q;
    logic       en_q;
    logic       acc_q;
    logic       wr_ok;

    assign wr_ok = wr_en && por_n && sys_rst_n;

    // Retained condition select and enable: cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            sel_q <= 3'b000;
            en_q  <= 1'b0;
        end else if (wr_ok && wr_addr == ADR_CTRL0) begin
            sel_q <= wr_data[2:0];
            en_q  <= wr_data[CTRL0_EN_BIT];
        end
    end

    // Compare register access enable: cleared by any reset.
    always_ff @(posedge clk) begin
        if (!por_n || !sys_rst_n) begin
            acc_q <= 1'b0;
        end else if (wr_ok && wr_addr == ADR_CTRL1) begin
            acc_q <= wr_data[CTRL1_ACC_BIT];
        end
    end

    assign sel_o    = sel_q;
    assign en_o     = en_q;
    assign acc_en_o = acc_q;

    // The retained fields must hold through a system reset.
    assert_retain_on_sys_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> ($stable(sel_o) && $stable(en_o)));

    // The access enable must be low right after any reset cycle.
    assert_acc_cleared_R6: assert property (@(posedge clk)
        !sys_rst_n |=> !acc_en_o);
endmodule

// File: rtl/dbg_cmp_bank.sv
// Compare address storage: NUM_CMP registers of ADDR_W bits, each laid out as
// consecutive bytes from the base address, low byte first. Access is gated by acc_en_i.
// The bytes are not reset, so their value is undefined until written.
module dbg_cmp_bank
    import dbg_watch_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                          clk,
    input  logic                          por_n,
    input  logic                          sys_rst_n,
    input  logic                          acc_en_i,
    input  logic                          wr_en,
    input  logic [REG_AW-1:0]             addr_i,
    input  logic [7:0]                    wr_data,
    output logic [7:0]                    rd_data,
    output logic                          rd_hit,
    output logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_o
);
    localparam int NBYTES = ADDR_W / 8;
    localparam int TOTAL  = NUM_CMP * NBYTES;

    logic [7:0] bytes_q [TOTAL];
    logic       wr_ok;

    assign wr_ok = wr_en && acc_en_i && por_n && sys_rst_n;

    for (genvar i = 0; i < TOTAL; i++) begin : g_byte
        localparam logic [REG_AW-1:0] MY_ADR = ADR_CMP_BASE + REG_AW'(i);
        // One byte lane of a compare register, written only while unlocked.
        always_ff @(posedge clk) begin
            if (wr_ok && addr_i == MY_ADR) begin
                bytes_q[i] <= wr_data;
            end
        end
    end

    for (genvar r = 0; r < NUM_CMP; r++) begin : g_reg
        for (genvar b = 0; b < NBYTES; b++) begin : g_lane
            assign cmp_o[r][b*8 +: 8] = bytes_q[r*NBYTES + b];
        end
    end

    // Byte read mux; locked reads return zero but still claim the address.
    always_comb begin
        rd_data = 8'h00;
        rd_hit  = 1'b0;
        for (int i = 0; i < TOTAL; i++) begin
            if (addr_i == ADR_CMP_BASE + REG_AW'(i)) begin
                rd_hit = 1'b1;
                if (acc_en_i) begin
                    rd_data = bytes_q[i];
                end
            end
        end
    end

    // A write with access disabled must not change any compare register.
    assert_locked_write_ignored_R4: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !acc_en_i) |=> $stable(cmp_o));

    // A locked read of a compare byte returns zero.
    assert_locked_read_zero_R4: assert property (@(posedge clk) disable iff (!por_n)
        (rd_hit && !acc_en_i) |-> (rd_data == 8'h00));
endmodule

// File: rtl/dbg_match_eval.sv
// Condition evaluation: compares the fetch address with the compare registers under the
// selected mode, registers the detect pulse and keeps the either-mode status bit.
// Assumes the fetch address is valid whenever strobe_i is high.
module dbg_match_eval
    import dbg_watch_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        sel_i,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] cmp0_i,
    input  logic [ADDR_W-1:0] cmp1_i,
    output logic              detect_o,
    output logic              which_o
);
    logic hit0, hit1, outside, cond, fire, either_fire;
    logic detect_q, which_q;

    assign hit0    = (addr_i == cmp0_i);
    assign hit1    = (addr_i == cmp1_i);
    assign outside = (addr_i < cmp0_i) || (addr_i > cmp1_i);

    // Condition decode by select code; unused codes give no condition.
    always_comb begin
        case (sel_i)
            SEL_CMP0:    cond = hit0;
            SEL_CMP1:    cond = hit1;
            SEL_EITHER:  cond = hit0 || hit1;
            SEL_OUTSIDE: cond = outside;
            default:     cond = 1'b0;
        endcase
    end

    assign fire        = strobe_i && en_i && cond;
    assign either_fire = fire && (sel_i == SEL_EITHER);

    // Detect pulse register: high for one cycle after a qualifying fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) detect_q <= 1'b0;
        else        detect_q <= fire;
    end

    // Either-mode status bit: register 0 wins when both match.
    always_ff @(posedge clk) begin
        if (!rst_n)           which_q <= 1'b0;
        else if (either_fire) which_q <= !hit0;
    end

    assign detect_o = detect_q;
    assign which_o  = which_q;

    // No pulse can follow a cycle without a fetch strobe.
    assert_pulse_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> !detect_o);

    // No pulse can follow a cycle with detection disabled.
    assert_no_detect_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !detect_o);

    // An either-mode hit on register 0 leaves the status bit at 0.
    assert_which_prefers_cmp0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && en_i && sel_i == SEL_EITHER && hit0) |=> (!which_o && detect_o));
endmodule

// File: rtl/dbg_addr_watch.sv
// Top of the fetch address watch unit: control registers, compare bank, condition
// evaluation and the combinational register read mux. Resets are synchronous, active low.
module dbg_addr_watch
    import dbg_watch_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              dbg_attached,
    input  logic              fetch_strobe,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              detect_pulse
);
    logic [2:0]                     sel;
    logic                           en;
    logic                           acc_en;
    logic [7:0]                     cmp_rdata;
    logic                           cmp_hit;
    logic [NUM_CMP-1:0][ADDR_W-1:0] cmp;
    logic                           which;
    logic                           eval_rst_n;

    assign eval_rst_n = por_n && sys_rst_n;

    dbg_ctrl_regs u_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .wr_en     (reg_we),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .sel_o     (sel),
        .en_o      (en),
        .acc_en_o  (acc_en)
    );

    dbg_cmp_bank #(.ADDR_W(ADDR_W)) u_cmp (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .acc_en_i  (acc_en),
        .wr_en     (reg_we),
        .addr_i    (reg_addr),
        .wr_data   (reg_wdata),
        .rd_data   (cmp_rdata),
        .rd_hit    (cmp_hit),
        .cmp_o     (cmp)
    );

    dbg_match_eval #(.ADDR_W(ADDR_W)) u_eval (
        .clk      (clk),
        .rst_n    (eval_rst_n),
        .strobe_i (fetch_strobe),
        .addr_i   (fetch_addr),
        .sel_i    (sel),
        .en_i     (en),
        .cmp0_i   (cmp[0]),
        .cmp1_i   (cmp[1]),
        .detect_o (detect_pulse),
        .which_o  (which)
    );

    // Register read mux with fixed reserved-bit values.
    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == ADR_CTRL0) begin
            reg_rdata[2:0]           = sel;
            reg_rdata[CTRL0_EN_BIT]  = en;
            reg_rdata[CTRL0_ONE_BIT] = 1'b1;
        end else if (reg_addr == ADR_CTRL1) begin
            reg_rdata[CTRL1_ACC_BIT]   = acc_en;
            reg_rdata[CTRL1_DBG_BIT]   = dbg_attached;
            reg_rdata[CTRL1_WHICH_BIT] = which;
        end else if (cmp_hit) begin
            reg_rdata = cmp_rdata;
        end
    end
endmodule

// File: tb/sim_dbg_addr_watch.sv
module sim_dbg_addr_watch;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst_n = 1'b1;
    logic [7:0]  reg_addr = 8'h00, reg_wdata = 8'h00;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic        dbg_attached = 1'b0;
    logic        fetch_strobe = 1'b0;
    logic [23:0] fetch_addr = 24'h0;
    logic        detect_pulse;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbg_addr_watch u0 (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dbg_attached(dbg_attached), .fetch_strobe(fetch_strobe), .fetch_addr(fetch_addr),
        .detect_pulse(detect_pulse)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    // Fetch one address with strobe, expect pulse next cycle only, then low.
    task automatic fetch(string req, logic [23:0] a, logic exp);
        @(negedge clk);
        fetch_strobe = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_strobe = 1'b0;
        check(req, {31'h0, detect_pulse}, {31'h0, exp});
        @(negedge clk);
        check({req, " R3 pulse width"}, {31'h0, detect_pulse}, 32'h0);
    endtask

    task automatic set_cmps(logic [23:0] c0, logic [23:0] c1);
        wr(8'h67, 8'h04);
        wr(8'h68, c0[7:0]);  wr(8'h69, c0[15:8]);  wr(8'h6A, c0[23:16]);
        wr(8'h6B, c1[7:0]);  wr(8'h6C, c1[15:8]);  wr(8'h6D, c1[23:16]);
    endtask

    task automatic t_reset;
        rd_check("R6 ctrl0 after por", 8'h66, 8'h80);
        rd_check("R7 ctrl1 no debugger", 8'h67, 8'h00);
        dbg_attached = 1'b1;
        rd_check("R7 ctrl1 debugger", 8'h67, 8'h08);
        dbg_attached = 1'b0;
        check("R3 idle after reset", {31'h0, detect_pulse}, 32'h0);
        rd_check("R8 unmapped", 8'h50, 8'h00);
    endtask

    task automatic t_access;
        set_cmps(24'h123456, 24'h200000);
        rd_check("R4 cmp0 low", 8'h68, 8'h56);
        rd_check("R4 cmp0 high", 8'h6A, 8'h12);
        rd_check("R4 cmp1 low", 8'h6B, 8'h00);
        rd_check("R4 cmp1 high", 8'h6D, 8'h20);
        wr(8'h67, 8'h00);
        rd_check("R4 locked read", 8'h68, 8'h00);
        wr(8'h68, 8'hFF);
        wr(8'h67, 8'h04);
        rd_check("R4 locked write ignored", 8'h68, 8'h56);
    endtask

    task automatic t_modes;
        wr(8'h66, 8'h11);
        fetch("R1 cmp0 hit", 24'h123456, 1'b1);
        fetch("R1 cmp0 neighbour", 24'h123457, 1'b0);
        fetch("R1 cmp0 other reg", 24'h200000, 1'b0);
        @(negedge clk);
        fetch_addr = 24'h123456;
        @(negedge clk); @(negedge clk);
        check("R3 no strobe no pulse", {31'h0, detect_pulse}, 32'h0);
        wr(8'h66, 8'h12);
        fetch("R1 cmp1 hit", 24'h200000, 1'b1);
        fetch("R1 cmp1 other reg", 24'h123456, 1'b0);
        wr(8'h66, 8'h13);
        fetch("R1 either cmp0", 24'h123456, 1'b1);
        rd_check("R5 which=0", 8'h67, 8'h04);
        fetch("R1 either cmp1", 24'h200000, 1'b1);
        rd_check("R5 which=1", 8'h67, 8'h24);
        fetch("R1 either miss", 24'h200001, 1'b0);
        rd_check("R5 miss keeps which", 8'h67, 8'h24);
        set_cmps(24'h200000, 24'h200000);
        fetch("R1 either both", 24'h200000, 1'b1);
        rd_check("R5 both gives 0", 8'h67, 8'h04);
    endtask

    task automatic t_outside;
        set_cmps(24'h100000, 24'h200000);
        wr(8'h66, 8'h15);
        fetch("R1 below low", 24'h0FFFFF, 1'b1);
        fetch("R1 at low", 24'h100000, 1'b0);
        fetch("R1 at high", 24'h200000, 1'b0);
        fetch("R1 above high", 24'h200001, 1'b1);
        wr(8'h66, 8'h13);
        fetch("R1 either mode", 24'h200000, 1'b1);
        rd_check("R5 which=1 again", 8'h67, 8'h24);
        wr(8'h66, 8'h15);
        fetch("R1 outside hit", 24'h000001, 1'b1);
        rd_check("R5 unchanged by other mode", 8'h67, 8'h24);
    endtask

    task automatic t_unused;
        for (int k = 0; k < 4; k++) begin
            logic [2:0] code;
            code = (k == 0) ? 3'b000 : (k == 1) ? 3'b100 : (k == 2) ? 3'b110 : 3'b111;
            wr(8'h66, {4'b0001, 1'b0, code});
            fetch("R1 unused code", 24'h100000, 1'b0);
        end
        wr(8'h66, 8'h01);
        fetch("R2 disabled cmp0", 24'h100000, 1'b0);
        wr(8'h66, 8'h05);
        fetch("R2 disabled outside", 24'h000000, 1'b0);
    endtask

    task automatic t_reserved;
        wr(8'h66, 8'hFF);
        rd_check("R7 ctrl0 reserved", 8'h66, 8'h97);
        wr(8'h67, 8'hFF);
        rd_check("R7 ctrl1 reserved", 8'h67, 8'h24);
    endtask

    task automatic t_resets;
        wr(8'h66, 8'h11);
        wr(8'h67, 8'h04);
        @(negedge clk); sys_rst_n = 1'b0;
        reg_addr = 8'h66; reg_wdata = 8'h00; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0; sys_rst_n = 1'b1;
        rd_check("R6 sys reset keeps ctrl0", 8'h66, 8'h91);
        rd_check("R6 sys reset clears ctrl1", 8'h67, 8'h00);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd_check("R6 por clears ctrl0", 8'h66, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        t_reset();
        t_access();
        t_modes();
        t_outside();
        t_unused();
        t_reserved();
        t_resets();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule